// File: doc/BRIEF.md
# Configuration Access Retry Engine

This block runs a configuration read or write that a requester starts through two registers. The target address is loaded into an address register first, then an access to the data port starts the transaction. The engine sends one configuration request toward the link and waits for its completion. When the completion carries Configuration Request Retry Status, the engine sends the same request again on the next cycle. It keeps doing so until some other status comes back, or until a programmable retry timer has run out.

The requester gets one acknowledgement per access. A read returns the completion payload on success. It returns all ones if the access timed out, was unsupported or was aborted by the completer. Failed outcomes set sticky error flags, and these can raise an interrupt. While an access is in flight the engine reports busy, and any further access waits at the data port until the engine is idle again.

Top module: `cfg_retry_engine`

## Requirements
- R1: After reset, busy, reqValid, rspValid, irq and all five error flags are 0.
- R2: An access presented while busy is 0 is accepted at the next clock edge and busy rises. In the following cycle reqValid is 1 for one cycle. It carries the address last written to the address register, the access direction (reqWrite 1 for a write) and the write data.
- R3: An access presented while busy is 1 is held off until busy falls. Accepted accesses reach the link and are answered in the order they were presented.
- R4: A completion with status 3'b010 (retry) that arrives before the timer has expired makes reqValid 1 again in the very next cycle, with the same address, direction and data.
- R5: The retry timer is cleared when an access is accepted. From the first request onward it counts one per cycle, and it is not restarted by retries. It counts as expired once its value is at least the 24-bit limit written through tmoWrEn, so a limit of 0 expires at once.
- R6: A retry completion that arrives after the timer has expired ends the access. A read returns 32'hFFFF_FFFF, and logCplTimeout is set.
- R7: Status 3'b001 (unsupported request), and any status code other than 3'b000, 3'b010 or 3'b100, ends the access. A read returns 32'hFFFF_FFFF, and logNotSucc and uncUr are set.
- R8: Status 3'b100 (completer abort) ends the access. A read returns 32'hFFFF_FFFF, and logCplAbort, logNotSucc and uncCa are set.
- R9: Status 3'b000 (success) ends a read with rspData equal to the completion payload, and it changes no error flag.
- R10: A write is acknowledged with rspData equal to 0 whatever its outcome. Its failures set the same flags as for a read.
- R11: The error flags are sticky until an errClear pulse clears them. irq is 1 exactly when irqEnable is 1 and at least one flag is set.
- R12: rspValid is a one-cycle pulse in the cycle after the final completion, and busy is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrWrEn | input | 1 | Load the address register |
| addrWrData | input | 32 | Configuration address value |
| tmoWrEn | input | 1 | Load the retry timer limit |
| tmoWrData | input | 24 | Retry limit in clock cycles |
| accValid | input | 1 | Access presented at the data port |
| accWrite | input | 1 | 1 = write access, 0 = read |
| accWrData | input | 32 | Write data of the access |
| busy | output | 1 | Access in flight |
| rspValid | output | 1 | Access finished (one-cycle pulse) |
| rspData | output | 32 | Read result, or 0 for writes |
| reqValid | output | 1 | Configuration request to the link |
| reqWrite | output | 1 | Request is a write |
| reqAddr | output | 32 | Request address |
| reqData | output | 32 | Request write data |
| cplValid | input | 1 | Completion from the link |
| cplStatus | input | 3 | Completion status code |
| cplData | input | 32 | Completion payload |
| irqEnable | input | 1 | Allow the error interrupt |
| errClear | input | 1 | Clear all error flags |
| logCplTimeout | output | 1 | Retry timeout seen |
| logNotSucc | output | 1 | Access did not succeed |
| logCplAbort | output | 1 | Completer abort seen |
| uncUr | output | 1 | Uncorrectable status: unsupported request |
| uncCa | output | 1 | Uncorrectable status: completer abort |
| irq | output | 1 | Error interrupt |

## Verification
The bound checker watches the local rules on every cycle:
- a request is only sent while busy;
- a retry completion is followed by either a reissue or a final response;
- each response comes one cycle after a completion, with busy low;
- abort and success read data are correct;
- writes return zero;
- an abort flag stays set until cleared.

Only the bench scenarios can show the behaviour that spans many cycles or depends on programmed values. That covers how many reissues fit inside a given timer limit, and the immediate abort when the limit is 0. It also covers the order of two overlapping accesses, which address each request carried, and how irqEnable gates the interrupt.

// File: rtl/cfgre_pkg.sv
package cfgre_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] ST_SC  = 3'b000;
  localparam logic [STAT_W-1:0] ST_UR  = 3'b001;
  localparam logic [STAT_W-1:0] ST_CRS = 3'b010;
  localparam logic [STAT_W-1:0] ST_CA  = 3'b100;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT
  } engState_t;

  typedef struct packed {
    logic accept;
    logic tick;
    logic finOk;
    logic finUr;
    logic finCa;
    logic finTmo;
  } ctlStrobe_t;
endpackage

// File: rtl/cfgre_ctrl.sv
module cfgre_ctrl
  import cfgre_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              cplValid,
  input  logic [STAT_W-1:0] cplStatus,
  input  logic              timerExpired,
  output ctlStrobe_t        strobe,
  output logic              busy,
  output logic              reqValid
);
  engState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      S_IDLE: begin
        if (accValid) begin
          strobe.accept = 1'b1;
          stateNxt      = S_ISSUE;
        end
      end
      S_ISSUE: begin
        strobe.tick = 1'b1;
        stateNxt    = S_WAIT;
      end
      S_WAIT: begin
        strobe.tick = 1'b1;
        if (cplValid) begin
          stateNxt = S_IDLE;
          if (cplStatus == ST_SC) begin
            strobe.finOk = 1'b1;
          end else if (cplStatus == ST_CRS) begin
            if (timerExpired) strobe.finTmo = 1'b1;
            else              stateNxt      = S_ISSUE;
          end else if (cplStatus == ST_CA) begin
            strobe.finCa = 1'b1;
          end else begin
            strobe.finUr = 1'b1;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign reqValid = (state == S_ISSUE);
endmodule

// File: rtl/cfgre_dp.sv
module cfgre_dp
  import cfgre_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          TMO_W     = 24,
  parameter int unsigned TMO_RESET = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              tmoWrEn,
  input  logic [TMO_W-1:0]  tmoWrData,
  input  logic              accWrite,
  input  logic [DATA_W-1:0] accWrData,
  input  logic [DATA_W-1:0] cplData,
  input  logic              errClear,
  output logic              timerExpired,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic              logCplTimeout,
  output logic              logNotSucc,
  output logic              logCplAbort,
  output logic              uncUr,
  output logic              uncCa
);
  localparam logic [TMO_W-1:0] TMO_MAX = '1;

  logic [ADDR_W-1:0] addrReg;
  logic [TMO_W-1:0]  tmoLimit;
  logic [TMO_W-1:0]  timer;
  logic              anyFin;
  logic              failFin;

  assign anyFin  = strobe.finOk | strobe.finUr | strobe.finCa | strobe.finTmo;
  assign failFin = strobe.finUr | strobe.finCa | strobe.finTmo;
  assign timerExpired = (timer >= tmoLimit);

  // Software-visible setup registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      tmoLimit <= TMO_W'(TMO_RESET);
    end else begin
      if (addrWrEn) addrReg  <= addrWrData;
      if (tmoWrEn)  tmoLimit <= tmoWrData;
    end
  end

  // Captured access, held for every retry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWrite <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
    end else if (strobe.accept) begin
      reqWrite <= accWrite;
      reqAddr  <= addrReg;
      reqData  <= accWrData;
    end
  end

  // Retry timer: cleared at accept, saturating count from first issue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.accept) begin
      timer <= '0;
    end else if (strobe.tick && (timer != TMO_MAX)) begin
      timer <= timer + 1'b1;
    end
  end

  // Response to the requester
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= anyFin;
      if (anyFin) begin
        if (reqWrite)          rspData <= '0;
        else if (failFin)      rspData <= '1;
        else                   rspData <= cplData;
      end
    end
  end

  // Sticky error log; a new error wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      logCplTimeout <= 1'b0;
      logNotSucc    <= 1'b0;
      logCplAbort   <= 1'b0;
      uncUr         <= 1'b0;
      uncCa         <= 1'b0;
    end else begin
      logCplTimeout <= strobe.finTmo | (logCplTimeout & ~errClear);
      logNotSucc    <= strobe.finUr | strobe.finCa | (logNotSucc & ~errClear);
      logCplAbort   <= strobe.finCa | (logCplAbort & ~errClear);
      uncUr         <= strobe.finUr | (uncUr & ~errClear);
      uncCa         <= strobe.finCa | (uncCa & ~errClear);
    end
  end
endmodule

// File: rtl/cfg_retry_engine.sv
module cfg_retry_engine
  import cfgre_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          TMO_W     = 24,
  parameter int unsigned TMO_RESET = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              tmoWrEn,
  input  logic [TMO_W-1:0]  tmoWrData,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [DATA_W-1:0] accWrData,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  input  logic              cplValid,
  input  logic [2:0]        cplStatus,
  input  logic [DATA_W-1:0] cplData,
  input  logic              irqEnable,
  input  logic              errClear,
  output logic              logCplTimeout,
  output logic              logNotSucc,
  output logic              logCplAbort,
  output logic              uncUr,
  output logic              uncCa,
  output logic              irq
);
  ctlStrobe_t strobe;
  logic       timerExpired;

  cfgre_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .accValid     (accValid),
    .cplValid     (cplValid),
    .cplStatus    (cplStatus),
    .timerExpired (timerExpired),
    .strobe       (strobe),
    .busy         (busy),
    .reqValid     (reqValid)
  );

  cfgre_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TMO_W     (TMO_W),
    .TMO_RESET (TMO_RESET)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .addrWrEn      (addrWrEn),
    .addrWrData    (addrWrData),
    .tmoWrEn       (tmoWrEn),
    .tmoWrData     (tmoWrData),
    .accWrite      (accWrite),
    .accWrData     (accWrData),
    .cplData       (cplData),
    .errClear      (errClear),
    .timerExpired  (timerExpired),
    .rspValid      (rspValid),
    .rspData       (rspData),
    .reqWrite      (reqWrite),
    .reqAddr       (reqAddr),
    .reqData       (reqData),
    .logCplTimeout (logCplTimeout),
    .logNotSucc    (logNotSucc),
    .logCplAbort   (logCplAbort),
    .uncUr         (uncUr),
    .uncCa         (uncCa)
  );

  assign irq = irqEnable &
               (logCplTimeout | logNotSucc | logCplAbort | uncUr | uncCa);
endmodule

// File: rtl/cfgre_chk.sv
module cfgre_chk
  import cfgre_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              cplValid,
  input logic [2:0]        cplStatus,
  input logic [DATA_W-1:0] cplData,
  input logic              uncCa,
  input logic              errClear
);
  // R2
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cplValid) |=> busy);

  // R4
  retry_or_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy && !reqValid && cplValid && cplStatus == ST_CRS) |-> (reqValid || rspValid));

  // R12
  rsp_after_cpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($past(cplValid) && !busy));

  // R12
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rspValid);

  // R8
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(cplValid && cplStatus == ST_CA && !reqWrite)) |-> (rspData == '1));

  // R9
  ok_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(cplValid && cplStatus == ST_SC && !reqWrite)) |-> (rspData == $past(cplData)));

  // R10
  write_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(reqWrite)) |-> (rspData == '0));

  // R11
  sticky_ca_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(uncCa) && !$past(errClear)) |-> uncCa);
endmodule

bind cfg_retry_engine cfgre_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .rspValid  (rspValid),
  .rspData   (rspData),
  .cplValid  (cplValid),
  .cplStatus (cplStatus),
  .cplData   (cplData),
  .uncCa     (uncCa),
  .errClear  (errClear)
);

// File: tb/cfg_retry_engine_tb_top.sv
module cfg_retry_engine_tb_top;
  localparam int CLK_NS = 20;
  localparam int DLY    = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrWrEn = 1'b0;
  logic [31:0] addrWrData = '0;
  logic        tmoWrEn = 1'b0;
  logic [23:0] tmoWrData = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accWrData = '0;
  logic        busy, rspValid, reqValid, reqWrite;
  logic [31:0] rspData, reqAddr, reqData;
  logic        cplValid = 1'b0;
  logic [2:0]  cplStatus = '0;
  logic [31:0] cplData = '0;
  logic        irqEnable = 1'b0;
  logic        errClear = 1'b0;
  logic        logCplTimeout, logNotSucc, logCplAbort, uncUr, uncCa, irq;

  int total = 0;
  int bad = 0;

  cfg_retry_engine dut_i (
    .clk(clk), .rstN(rstN),
    .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .tmoWrEn(tmoWrEn), .tmoWrData(tmoWrData),
    .accValid(accValid), .accWrite(accWrite), .accWrData(accWrData),
    .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData),
    .cplValid(cplValid), .cplStatus(cplStatus), .cplData(cplData),
    .irqEnable(irqEnable), .errClear(errClear),
    .logCplTimeout(logCplTimeout), .logNotSucc(logNotSucc), .logCplAbort(logCplAbort),
    .uncUr(uncUr), .uncCa(uncCa), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- link model ----------------
  logic [2:0]  statQ[$];
  logic [2:0]  dfltStatus = 3'b000;
  logic [31:0] payBase = '0;
  int          linkReqs = 0;
  logic [31:0] seenAddr[$];
  logic        seenWrite[$];
  logic [31:0] seenData[$];

  initial begin
    forever begin
      @(negedge clk);
      while (rstN && reqValid) begin
        linkReqs++;
        seenAddr.push_back(reqAddr);
        seenWrite.push_back(reqWrite);
        seenData.push_back(reqData);
        repeat (DLY) @(negedge clk);
        cplStatus = (statQ.size() != 0) ? statQ.pop_front() : dfltStatus;
        cplData   = payBase ^ 32'(linkReqs);
        cplValid  = 1'b1;
        @(negedge clk);
        cplValid  = 1'b0;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expQ[$];

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected response", rspData, 32'h0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R9/R6/R7/R8/R10 response data", rspData, e);
        end
        check(busy == 1'b0, "R12 busy low with response", 32'(busy), 32'h0);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic setAddr(input logic [31:0] a);
    addrWrData = a; addrWrEn = 1'b1;
    @(negedge clk); addrWrEn = 1'b0;
  endtask

  task automatic setTmo(input logic [23:0] t);
    tmoWrData = t; tmoWrEn = 1'b1;
    @(negedge clk); tmoWrEn = 1'b0;
  endtask

  task automatic doAccess(input bit w, input logic [31:0] d, input logic [31:0] e);
    expQ.push_back(e);
    accWrite = w; accWrData = d; accValid = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || expQ.size() != 0 || cplValid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic startTest();
    linkReqs = 0;
    seenAddr.delete(); seenWrite.delete(); seenData.delete();
  endtask

  task automatic clearErr();
    errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] logs();
    return {27'h0, logCplTimeout, logNotSucc, logCplAbort, uncUr, uncCa};
  endfunction

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, reqValid, rspValid, irq} == 4'b0, "R1 reset outputs",
          32'({busy, reqValid, rspValid, irq}), 32'h0);
    check(logs() == 32'h0, "R1 reset flags", logs(), 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R9 successful read
    setTmo(24'd100);
    setAddr(32'h0000_1004);
    startTest(); payBase = 32'hCAFE_0000; dfltStatus = 3'b000;
    doAccess(1'b0, 32'h0, 32'hCAFE_0001);
    waitIdle();
    check(linkReqs == 1, "R2 one request", 32'(linkReqs), 32'd1);
    check(seenAddr[0] == 32'h0000_1004 && seenWrite[0] == 1'b0, "R2 request address",
          seenAddr[0], 32'h0000_1004);
    check(logs() == 32'h0, "R9 no flags on success", logs(), 32'h0);

    // R10 / R2 successful write
    startTest();
    doAccess(1'b1, 32'h0000_55AA, 32'h0);
    waitIdle();
    check(seenWrite[0] == 1'b1 && seenData[0] == 32'h0000_55AA, "R2 write request data",
          seenData[0], 32'h0000_55AA);

    // R4 retry twice then success
    startTest(); payBase = 32'h1234_5670;
    statQ.push_back(3'b010); statQ.push_back(3'b010); statQ.push_back(3'b000);
    doAccess(1'b0, 32'h0, 32'h1234_5673);
    waitIdle();
    check(linkReqs == 3, "R4 reissue count", 32'(linkReqs), 32'd3);
    check(seenAddr[2] == 32'h0000_1004, "R4 reissue address", seenAddr[2], 32'h0000_1004);

    // R5 / R6 timeout: limit 10, delay 2 -> issues at 0,3,6,9; abort at 11
    setTmo(24'd10);
    startTest(); dfltStatus = 3'b010;
    doAccess(1'b0, 32'h0, 32'hFFFF_FFFF);
    waitIdle();
    check(linkReqs == 4, "R5 issues within limit", 32'(linkReqs), 32'd4);
    check(logs() == 32'h10, "R6 timeout flag only", logs(), 32'h10);
    check(irq == 1'b0, "R11 irq masked", 32'(irq), 32'h0);
    irqEnable = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R11 irq enabled", 32'(irq), 32'h1);
    clearErr();
    check(logs() == 32'h0 && irq == 1'b0, "R11 clear", logs(), 32'h0);

    // R5 boundary: limit 0 aborts on first retry status
    setTmo(24'd0);
    startTest();
    doAccess(1'b0, 32'h0, 32'hFFFF_FFFF);
    waitIdle();
    check(linkReqs == 1, "R5 zero limit", 32'(linkReqs), 32'd1);
    clearErr();
    setTmo(24'd100);
    dfltStatus = 3'b000;

    // R7 unsupported request
    startTest(); statQ.push_back(3'b001);
    doAccess(1'b0, 32'h0, 32'hFFFF_FFFF);
    waitIdle();
    check(logs() == 32'h0A, "R7 UR flags", logs(), 32'h0A);
    clearErr();

    // R7 reserved code behaves as unsupported
    startTest(); statQ.push_back(3'b011);
    doAccess(1'b0, 32'h0, 32'hFFFF_FFFF);
    waitIdle();
    check(logs() == 32'h0A, "R7 reserved code flags", logs(), 32'h0A);
    clearErr();

    // R8 completer abort
    startTest(); statQ.push_back(3'b100);
    doAccess(1'b0, 32'h0, 32'hFFFF_FFFF);
    waitIdle();
    check(logs() == 32'h0D, "R8 CA flags", logs(), 32'h0D);
    clearErr();

    // R10 write with completer abort: zero ack, flags logged
    startTest(); statQ.push_back(3'b100);
    doAccess(1'b1, 32'hDEAD_BEEF, 32'h0);
    waitIdle();
    check(logs() == 32'h0D, "R10 write abort flags", logs(), 32'h0D);
    clearErr();

    // R3 stall: second access waits, order kept
    startTest(); payBase = 32'hD0DE_0000;
    setAddr(32'h0000_0A00);
    doAccess(1'b0, 32'h0, 32'hD0DE_0001);
    setAddr(32'h0000_0B00);
    check(busy == 1'b1, "R3 busy during access", 32'(busy), 32'h1);
    doAccess(1'b0, 32'h0, 32'hD0DE_0002);
    waitIdle();
    check(linkReqs == 2, "R3 request count", 32'(linkReqs), 32'd2);
    check(seenAddr[0] == 32'h0000_0A00, "R3 first address", seenAddr[0], 32'h0000_0A00);
    check(seenAddr[1] == 32'h0000_0B00, "R3 second address", seenAddr[1], 32'h0000_0B00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule